// File: doc/BRIEF.md
# Multicast Response Queue with Empty Bypass

This block holds response packets from a cache pipeline until the crossbar toward the processor cores can take them. It is a first-in first-out queue of 16 entries, each 146 bits of payload plus a destination bitmask. The pipeline writes into it and the crossbar side reads from it. A packet leaves the head only when every destination named in its mask reports ready in that cycle. A unicast packet names one destination. A multicast packet names several, and all of them must be ready at once, or it stays at the head and blocks the packets behind it.

When the queue is empty, an arriving packet whose destinations are all ready goes straight to the output register and is never written into storage. The block compares its occupancy against a high-water level that software or the pipeline configuration sets. When occupancy reaches that level it raises a registered stall flag, so the pipeline stops starting new work while the operations already in flight still find space. Fill operations arrive on the same input with a marker bit set. They produce no response, so the block takes them even when it is full and they leave no trace.

Top module: `mcast_resp_queue`

## Requirements
- R1: Stored packets leave in arrival order. No packet is lost or duplicated while the pipeline honours the stall, with at most two operations in flight after the stall is seen and `hwm_level` no greater than 14. With the default parameters the storage holds 16 entries of 146 bits.
- R2: When the queue is empty and the arriving packet has every destination in `in_dest` ready on `dest_ready`, the packet appears on `out_data`/`out_dest` with `out_valid` high one cycle later, and occupancy stays zero.
- R3: While the queue holds an entry, the head competes for the output and an arriving packet is stored behind it. The bypass path is not used then.
- R4: A candidate issues only if `(dest & ~dest_ready) == 0`, where bit i of each mask means destination i. Otherwise it stays at the head and `out_valid` is low in the next cycle.
- R5: A unicast packet, with exactly one mask bit set, issues when that single destination is ready, whatever the other ready bits are. A packet with an empty mask is illegal.
- R6: `stall` is high in a cycle exactly when occupancy is at least the `hwm_level` value present before the last clock edge.
- R7: A push and a pop in the same cycle leave occupancy unchanged.
- R8: An input with `in_valid` and `in_fill` both high is accepted in every state, including full. It is never stored or issued, and it changes neither occupancy nor the order of stored packets.
- R9: Synchronous reset empties the queue, clears `out_valid`, and sets `stall` to the result of `hwm_level == 0`.
- R10: The outputs are registered. `out_valid` is high for exactly one cycle per issued packet and low in every cycle that follows a cycle without an issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pipeline presents an operation |
| in_fill | input | 1 | Operation is a fill that yields no response |
| in_data | input | DATA_W (146) | Response payload |
| in_dest | input | NDEST (4) | Destination bitmask, bit i selects destination i |
| hwm_level | input | CNT_W (5) | High-water occupancy level |
| stall | output | 1 | Occupancy has reached the high-water level |
| dest_ready | input | NDEST (4) | Per-destination readiness from the crossbar queues |
| out_valid | output | 1 | A packet is issued this cycle |
| out_data | output | DATA_W (146) | Issued payload |
| out_dest | output | NDEST (4) | Issued destination mask |

## Verification
If a pointer or the occupancy count is wrong, the first symptom at the ports is an out-of-order, repeated or missing payload, or a `stall` level that disagrees with the arithmetic occupancy. Either shows within one cycle of the next issue or the next edge. If the destination-ready check is wrong, `out_valid` is raised one cycle after a cycle in which some named destination was not ready. If the bypass takes a wrong turn, one of two things shows: the first packet into an empty queue is late by one or more cycles, or, with a high-water level of 1, `stall` rises even though nothing should have been stored. The bench drives near-exhaustive patterns of masks, readiness, fills and high-water levels on a small configuration, and compares every output in every cycle against an arithmetic queue model.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  // Which source feeds the issue stage in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_HEAD   = 2'd1,
    SRC_BYPASS = 2'd2
  } cand_src_e;
endpackage

// File: rtl/mrq_store.sv
// Payload and mask storage: one synchronous write port, one asynchronous
// read port, so that distributed RAM can be inferred.
module mrq_store #(
  parameter int DATA_W = 146,
  parameter int NDEST  = 4,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NDEST-1:0]  wr_dest,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NDEST-1:0]  rd_dest
);
  localparam int ENT_W = DATA_W + NDEST;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_dest, wr_data};
  end

  assign {rd_dest, rd_data} = mem[rd_addr];
endmodule

// File: rtl/mrq_ptrs.sv
// Read and write pointers, occupancy counter and the registered high-water stall.
module mrq_ptrs #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] hwm_level,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             q_empty,
  output logic [CNT_W-1:0] cnt,
  output logic             stall
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             q_full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign q_empty = (cnt == '0);
  assign q_full  = (cnt == CNT_W'(DEPTH));

  always_comb begin
    cnt_nxt = cnt + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      stall  <= (hwm_level == '0);
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt   <= cnt_nxt;
      stall <= (cnt_nxt >= hwm_level);
    end
  end

  // R1: a push into a full queue would overwrite the head
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    push |-> (!q_full || pop));

  // R1: a pop from an empty queue would replay stale data
  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (rst)
    pop |-> !q_empty);

  // R7: push and pop together keep occupancy
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (cnt == $past(cnt)));

  // R6: stall tracks occupancy against the level seen before the edge
  assert_stall_level_R6: assert property (@(posedge clk) disable iff (rst)
    stall == (cnt >= $past(hwm_level)));
endmodule

// File: rtl/mrq_issue.sv
// Picks the head or the bypassed input, checks all named destinations
// are ready, and registers the issued packet.
module mrq_issue
  import mrq_pkg::*;
#(
  parameter int DATA_W = 146,
  parameter int NDEST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic [NDEST-1:0]  head_dest,
  input  logic              in_valid,
  input  logic              in_fill,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NDEST-1:0]  in_dest,
  input  logic [NDEST-1:0]  dest_ready,
  output logic              push,
  output logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [NDEST-1:0]  out_dest
);
  cand_src_e         src;
  logic [DATA_W-1:0] cand_data;
  logic [NDEST-1:0]  cand_dest;
  logic              all_ready;
  logic              fire;
  logic              pkt_in;

  assign pkt_in = in_valid && !in_fill;

  always_comb begin
    if (!q_empty)    src = SRC_HEAD;
    else if (pkt_in) src = SRC_BYPASS;
    else             src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_HEAD: begin
        cand_data = head_data;
        cand_dest = head_dest;
      end
      SRC_BYPASS: begin
        cand_data = in_data;
        cand_dest = in_dest;
      end
      default: begin
        cand_data = '0;
        cand_dest = '0;
      end
    endcase
  end

  assign all_ready = ((cand_dest & ~dest_ready) == '0);
  assign fire      = (src != SRC_NONE) && all_ready;
  assign pop       = fire && (src == SRC_HEAD);
  assign push      = pkt_in && !(fire && (src == SRC_BYPASS));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data <= cand_data;
        out_dest <= cand_dest;
      end
    end
  end

  // R4: every destination of an issued packet was ready when it was chosen
  assert_issue_ready_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_dest & ~$past(dest_ready)) == '0));

  // R3: with a stored head, an arriving packet must be stored
  assert_head_first_R3: assert property (@(posedge clk) disable iff (rst)
    (!q_empty && pkt_in) |-> push);
endmodule

// File: rtl/mcast_resp_queue.sv
module mcast_resp_queue #(
  parameter int DATA_W = 146,
  parameter int NDEST  = 4,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_fill,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NDEST-1:0]  in_dest,
  input  logic [CNT_W-1:0]  hwm_level,
  output logic              stall,
  input  logic [NDEST-1:0]  dest_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [NDEST-1:0]  out_dest
);
  logic              push, pop, q_empty;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] head_data;
  logic [NDEST-1:0]  head_dest;

  mrq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .hwm_level(hwm_level),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .q_empty(q_empty), .cnt(cnt),
    .stall(stall)
  );

  mrq_store #(.DATA_W(DATA_W), .NDEST(NDEST), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .wr_en(push), .wr_addr(wr_ptr), .wr_data(in_data),
    .wr_dest(in_dest), .rd_addr(rd_ptr), .rd_data(head_data),
    .rd_dest(head_dest)
  );

  mrq_issue #(.DATA_W(DATA_W), .NDEST(NDEST)) u_issue (
    .clk(clk), .rst(rst), .q_empty(q_empty), .head_data(head_data),
    .head_dest(head_dest), .in_valid(in_valid), .in_fill(in_fill),
    .in_data(in_data), .in_dest(in_dest), .dest_ready(dest_ready),
    .push(push), .pop(pop), .out_valid(out_valid), .out_data(out_data),
    .out_dest(out_dest)
  );

  // R5: a response must name at least one destination
  assert_dest_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_fill) |-> (in_dest != '0));

  // R8: a fill into an empty queue yields no issue
  assert_fill_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_fill && q_empty) |=> !out_valid);
endmodule

// File: tb/mcast_resp_queue_test.sv
module mcast_resp_queue_test;
  localparam int DW = 146;
  localparam int ND = 4;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_fill;
  logic [DW-1:0] in_data;
  logic [ND-1:0] in_dest, dest_ready, out_dest;
  logic [4:0]    hwm;
  logic          stall, out_valid;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  int seq = 0, n_in = 0, n_out = 0;
  logic [DW-1:0] md [64];
  logic [ND-1:0] mdst [64];
  int mh = 0, mt = 0, mc = 0;

  mcast_resp_queue uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fill(in_fill),
    .in_data(in_data), .in_dest(in_dest), .hwm_level(hwm), .stall(stall),
    .dest_ready(dest_ready), .out_valid(out_valid), .out_data(out_data),
    .out_dest(out_dest)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [DW-1:0] mk(input int s);
    logic [31:0] h;
    h = s * 32'h9E3779B1 + 32'h7F4A7C15;
    return {s[17:0], h, ~h, h ^ 32'h5A5A5A5A, {h[15:0], h[31:16]}};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // One clock cycle: drive inputs, predict, advance, compare, update model.
  task automatic cyc(input logic v, input logic f, input logic [ND-1:0] d,
                     input logic [ND-1:0] rdy, input string tag);
    logic [DW-1:0] dat, cdat;
    logic [ND-1:0] cdst;
    logic cv, iss, psh, pp;
    dat = mk(seq);
    in_valid = v; in_fill = f; in_data = dat; in_dest = d; dest_ready = rdy;
    cv = 1'b0; cdat = '0; cdst = '0;
    if (mc > 0) begin
      cv = 1'b1; cdat = md[mh % 64]; cdst = mdst[mh % 64];
    end else if (v && !f) begin
      cv = 1'b1; cdat = dat; cdst = d;
    end
    iss = cv && ((cdst & ~rdy) == '0);
    psh = v && !f && !(mc == 0 && iss);
    pp  = (mc > 0) && iss;
    @(posedge clk); #1;
    if (pp) begin mh++; mc--; end
    if (psh) begin md[mt % 64] = dat; mdst[mt % 64] = d; mt++; mc++; end
    if (v && !f) begin seq++; n_in++; end
    if (iss) n_out++;
    chk(tag, "out_valid", DW'(out_valid), DW'(iss));
    if (iss) begin
      chk(tag, "out_data", out_data, cdat);
      chk(tag, "out_dest", DW'(out_dest), DW'(cdst));
    end
    chk("R6", "stall", DW'(stall), DW'(mc >= int'(hwm)));
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 40 && mc > 0; i++) cyc(1'b0, 1'b0, '0, '1, tag);
    cyc(1'b0, 1'b0, '0, '1, tag);
  endtask

  function automatic logic [ND-1:0] rmask(input bit uni);
    logic [ND-1:0] m;
    if (uni) return ND'(1) << ($urandom % ND);
    m = ND'($urandom);
    if (m == '0) m = ND'(1);
    return m;
  endfunction

  // Pipeline with two stages in flight; new work starts only without stall.
  task automatic rand_phase(input int n, input int pv, input int pf, input int pr);
    logic v0 = 0, f0 = 0, v1 = 0, f1 = 0;
    logic [ND-1:0] d0 = '0, d1 = '0, rdy;
    bit want;
    for (int c = 0; c < n + 2; c++) begin
      v1 = v0; f1 = f0; d1 = d0;
      want = (c < n) && (($urandom % 100) < pv);
      v0 = 0; f0 = 0; d0 = '0;
      if (want && (($urandom % 100) < pf)) begin
        v0 = 1; f0 = 1; d0 = '0;
      end else if (want && !stall) begin
        v0 = 1; f0 = 0; d0 = rmask(($urandom % 2) == 0);
      end
      rdy = '0;
      for (int b = 0; b < ND; b++) rdy[b] = (($urandom % 100) < pr);
      cyc(v1, f1, d1, rdy, "R1");
    end
  endtask

  initial begin
    rst = 1; in_valid = 0; in_fill = 0; in_data = '0; in_dest = '0;
    dest_ready = '0; hwm = 5'd0;
    repeat (2) @(posedge clk); #1;
    chk("R9", "stall with level 0", DW'(stall), DW'(1));
    chk("R9", "out_valid in reset", DW'(out_valid), DW'(0));
    hwm = 5'd4;
    @(posedge clk); #1;
    chk("R9", "stall with level 4", DW'(stall), DW'(0));
    @(negedge clk); rst = 0;

    // R2: bypass while empty; level 1 shows nothing is stored
    hwm = 5'd1;
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, ND'(1) << (i % ND), '1, "R2");
    cyc(1'b0, 1'b0, '0, '1, "R10");
    chk("R10", "out_valid after idle", DW'(out_valid), DW'(0));

    // R4: multicast held at the head until every destination is ready
    hwm = 5'd8;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 4'b1011, 4'b0011, "R4");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0, 4'b1001, "R4");
    chk("R4", "held count", DW'(mc), DW'(3));
    // R3: head goes first while a new packet arrives
    cyc(1'b1, 1'b0, 4'b0001, 4'b1111, "R3");
    drain("R1");

    // R5: unicast needs only its own destination
    cyc(1'b1, 1'b0, 4'b0100, 4'b0100, "R5");
    cyc(1'b1, 1'b0, 4'b0010, 4'b0000, "R5");
    cyc(1'b1, 1'b0, 4'b0010, 4'b1101, "R5");
    cyc(1'b0, 1'b0, '0, 4'b0010, "R5");
    cyc(1'b0, 1'b0, '0, 4'b0010, "R5");
    chk("R5", "unicast drained", DW'(mc), DW'(0));

    // R6/R7: reach the level, then push+pop keeps stall high
    hwm = 5'd3;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 4'b0001, 4'b0000, "R6");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 4'b0001, 4'b0001, "R7");
    chk("R7", "count under push+pop", DW'(mc), DW'(3));
    drain("R1");

    // R8: fill into empty, then fills while full
    cyc(1'b1, 1'b1, '0, '1, "R8");
    hwm = 5'd14;
    for (int i = 0; i < DP; i++) cyc(1'b1, 1'b0, ND'(1) << (i % ND), '0, "R8");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, '0, '0, "R8");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, '0, '1, "R8");
    chk("R8", "full count after fills", DW'(mc), DW'(DP - 4));
    drain("R1");

    // R1: sweep of levels with random traffic that honours the stall
    for (int lv = 1; lv <= 14; lv++) begin
      hwm = 5'(lv);
      rand_phase(300, 30 + (lv * 5), 15, 40 + (lv % 4) * 15);
      drain("R1");
    end
    chk("R1", "issued equals accepted", DW'(n_out), DW'(n_in));
    chk("R1", "queue empty at end", DW'(mc), DW'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule